// File: doc/BRIEF.md
# Host-to-DSP Parallel Mailbox

This block links an external host processor to a DSP core through a pair of one-word mailboxes, one for each direction. A word the host writes into its transmit holding register moves into the DSP receive register, and a word the DSP writes into its transmit holding register moves into the host receive register. Each holding register has an empty or full flag. A word moves only when its destination is free, and it moves one clock after it is written.

On the DSP side a five-bit status word shows five things: receive-full, transmit-empty, a pending host command, and two general-purpose flags that the host sets through its control write. The host can post a command with a vector. The command stays pending and raises a level interrupt until the DSP acknowledges it or the host withdraws it. The host can also run an initialize that empties the DSP transmit path.

The empty and full conditions drive either DMA requests or interrupt requests. The choice depends on a host DMA enable bit, and that bit is suppressed while the request/acknowledge pin mode is selected.

Top module: `hostdsp_mailbox`

## Requirements
- R1: After a synchronous active-low reset, `dsp_status` reads 5'b00010. `host_tx_empty` is 1. `host_rx_full`, `cmd_irq`, `host_cmd_busy` and `dma_enabled` are 0.
- R2: The `dsp_status` bits are: bit 0 receive-full, bit 1 transmit-empty, bit 2 command pending, bit 3 host flag 0, bit 4 host flag 1.
- R3: A host word written at clock edge N appears on `dsp_rx_data` with receive-full at 1 after edge N+1, if receive-full was 0 at edge N+1. If not, the word waits and `host_tx_empty` stays 0. `host_tx_empty` returns to 1 when the word moves, unless a new host write lands in that same cycle.
- R4: `dsp_rx_rd` clears receive-full. If a new word arrives in the same cycle as the read, receive-full stays 1 and the new word is shown.
- R5: A DSP write clears transmit-empty. At the next edge the word moves to `host_rx_data`, `host_rx_full` goes to 1 and transmit-empty goes back to 1, provided `host_rx_full` is 0. `host_rx_rd` clears `host_rx_full`.
- R6: `host_init` sets transmit-empty to 1 and discards any DSP word that has not yet moved. It takes priority over a DSP write in the same cycle.
- R7: `host_ctl_wr` copies `host_ctl_flags` into status bits 4:3. The flags change only on that write.
- R8: `host_cmd_set` sets command pending and latches `host_cmd_vec` onto `cmd_vector`. `cmd_ack` or `host_cmd_clr` clears command pending. When several arrive together, clear beats set and set beats ack. `cmd_irq` and `host_cmd_busy` both equal command pending.
- R9: Let the enable be `dma_enabled`. `tx_dma_req` = transmit-empty AND enable, and `rx_dma_req` = receive-full AND enable. `tx_irq` and `rx_irq` carry the same two conditions when the enable is 0.
- R10: `host_ctl_wr` latches the DMA bit, and reset clears it. `dma_enabled` is that bit AND NOT `host_pin_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_tx_wr | input | 1 | Host writes its transmit holding register |
| host_tx_data | input | DATA_W | Host transmit word |
| host_tx_empty | output | 1 | Host transmit holding register is free |
| host_rx_rd | input | 1 | Host reads its receive register |
| host_rx_data | output | DATA_W | Word from the DSP |
| host_rx_full | output | 1 | Host receive register holds a word |
| host_ctl_wr | input | 1 | Host control write (flags and DMA bit) |
| host_ctl_flags | input | 2 | General-purpose flags for the DSP |
| host_ctl_dma | input | 1 | Host DMA enable bit |
| host_pin_mode | input | 1 | Request/acknowledge pin mode selected |
| host_init | input | 1 | Initialize: force DSP transmit-empty |
| host_cmd_set | input | 1 | Post a host command |
| host_cmd_clr | input | 1 | Withdraw the host command |
| host_cmd_vec | input | VEC_W | Vector latched with the command |
| host_cmd_busy | output | 1 | Host view of the command bit |
| dsp_tx_wr | input | 1 | DSP writes its transmit holding register |
| dsp_tx_data | input | DATA_W | DSP transmit word |
| dsp_rx_rd | input | 1 | DSP reads its receive register |
| dsp_rx_data | output | DATA_W | Word from the host |
| dsp_status | output | 5 | DSP status word (see R2) |
| cmd_irq | output | 1 | Level command interrupt to the DSP |
| cmd_vector | output | VEC_W | Latched command vector |
| cmd_ack | input | 1 | One-cycle service acknowledge from the DSP |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |
| dma_enabled | output | 1 | Effective DMA enable |

## Verification
A behavioural model runs next to the design and is compared on every clock while all host and DSP strobes are driven at mixed rates. The model checks both directions against back-pressure: a held word is told apart from a moved one by writing while the far side is still full. Strobes that collide often, such as a read during an arrival, an initialize during a DSP write, and set, clear and ack together, separate the priority orders of R4, R6 and R8. Toggling the pin mode while the DMA bit is set separates the DMA and interrupt routing of R9 and R10.

// File: rtl/hdm_pkg.sv
// Shared types for the host/DSP mailbox.
// Assumes: status layout is fixed by software that decodes it.
package hdm_pkg;
    localparam int STAT_W = 5;

    // DSP status word; first member lands in the top bit.
    typedef struct packed {
        logic [1:0] hflag;   // bits 4:3
        logic       hcp;     // bit 2
        logic       tde;     // bit 1
        logic       rdf;     // bit 0
    } dsp_stat_t;
endpackage

// File: rtl/hdm_channel.sv
// One-direction, one-word mailbox: a source holding register with an
// empty flag and a destination register with a full flag.
// Assumes: the word moves one edge after it is written, only when the
// destination is free; a flush empties the source and blocks the move.
module hdm_channel #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         src_wr,
    input  logic [W-1:0] src_data,
    input  logic         src_flush,
    input  logic         dst_rd,
    output logic         src_empty,
    output logic         dst_full,
    output logic [W-1:0] dst_data
);
    logic [W-1:0] src_q;
    logic [W-1:0] dst_q;
    logic         empty_q;
    logic         full_q;
    logic         move;

    // Transfer condition: a held word and a free destination.
    assign move = !empty_q && !full_q && !src_flush;

    // Source holding register: flush beats write beats transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q   <= '0;
            empty_q <= 1'b1;
        end else if (src_flush) begin
            empty_q <= 1'b1;
        end else if (src_wr) begin
            src_q   <= src_data;
            empty_q <= 1'b0;
        end else if (move) begin
            empty_q <= 1'b1;
        end
    end

    // Destination register: arrival beats read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_q  <= '0;
            full_q <= 1'b0;
        end else if (move) begin
            dst_q  <= src_q;
            full_q <= 1'b1;
        end else if (dst_rd) begin
            full_q <= 1'b0;
        end
    end

    assign src_empty = empty_q;
    assign dst_full  = full_q;
    assign dst_data  = dst_q;

    // R3 / R5: a held word with a free destination arrives next edge.
    p_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_empty && !dst_full && !src_flush) |=> (dst_full && dst_data == $past(src_q)));
    // R4: a read of a full destination with nothing arriving empties it.
    p_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_rd && dst_full) |=> !dst_full);
    // R6: a flush always leaves the source empty.
    p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        src_flush |=> src_empty);
endmodule

// File: rtl/hdm_host_ctl.sv
// Host control state: general-purpose flags, DMA enable bit and the
// host command with its vector.
// Assumes: cmd_ack is a one-cycle pulse; clear beats set beats ack.
module hdm_host_ctl #(
    parameter int VEC_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [1:0]       ctl_flags,
    input  logic             ctl_dma,
    input  logic             cmd_set,
    input  logic             cmd_clr,
    input  logic [VEC_W-1:0] cmd_vec_in,
    input  logic             cmd_ack,
    output logic [1:0]       flags,
    output logic             dma_bit,
    output logic             cmd_pend,
    output logic [VEC_W-1:0] cmd_vec
);
    logic [1:0]       flags_q;
    logic             dma_q;
    logic             pend_q;
    logic [VEC_W-1:0] vec_q;

    // Control write: flags and DMA bit together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            dma_q   <= 1'b0;
        end else if (ctl_wr) begin
            flags_q <= ctl_flags;
            dma_q   <= ctl_dma;
        end
    end

    // Command bit: host clear, then host set, then DSP acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            vec_q  <= '0;
        end else if (cmd_clr) begin
            pend_q <= 1'b0;
        end else if (cmd_set) begin
            pend_q <= 1'b1;
            vec_q  <= cmd_vec_in;
        end else if (cmd_ack) begin
            pend_q <= 1'b0;
        end
    end

    assign flags    = flags_q;
    assign dma_bit  = dma_q;
    assign cmd_pend = pend_q;
    assign cmd_vec  = vec_q;

    // R7: flags are stable without a control write.
    p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(flags));
    // R8: an acknowledge alone retires the command.
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ack && !cmd_set) |=> !cmd_pend);
    // R8: a host clear always wins.
    p_clr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_clr |=> !cmd_pend);
endmodule

// File: rtl/hdm_req.sv
// Routes each condition to a DMA request or an interrupt request.
// Assumes: dma_on is the already-gated effective enable.
module hdm_req #(
    parameter int N = 2
) (
    input  logic [N-1:0] cond,
    input  logic         dma_on,
    output logic [N-1:0] dma_req,
    output logic [N-1:0] irq
);
    for (genvar i = 0; i < N; i++) begin : g_route
        // One condition, one of two destinations.
        always_comb begin
            dma_req[i] = cond[i] && dma_on;
            irq[i]     = cond[i] && !dma_on;
        end
    end
endmodule

// File: rtl/hostdsp_mailbox.sv
// Top of the host/DSP mailbox: two one-word channels, host control
// state and request routing.
// Assumes: all strobes are single-cycle and synchronous to clk.
module hostdsp_mailbox #(
    parameter int DATA_W = 24,
    parameter int VEC_W  = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_tx_wr,
    input  logic [DATA_W-1:0]          host_tx_data,
    output logic                       host_tx_empty,
    input  logic                       host_rx_rd,
    output logic [DATA_W-1:0]          host_rx_data,
    output logic                       host_rx_full,
    input  logic                       host_ctl_wr,
    input  logic [1:0]                 host_ctl_flags,
    input  logic                       host_ctl_dma,
    input  logic                       host_pin_mode,
    input  logic                       host_init,
    input  logic                       host_cmd_set,
    input  logic                       host_cmd_clr,
    input  logic [VEC_W-1:0]           host_cmd_vec,
    output logic                       host_cmd_busy,
    input  logic                       dsp_tx_wr,
    input  logic [DATA_W-1:0]          dsp_tx_data,
    input  logic                       dsp_rx_rd,
    output logic [DATA_W-1:0]          dsp_rx_data,
    output logic [hdm_pkg::STAT_W-1:0] dsp_status,
    output logic                       cmd_irq,
    output logic [VEC_W-1:0]           cmd_vector,
    input  logic                       cmd_ack,
    output logic                       tx_dma_req,
    output logic                       rx_dma_req,
    output logic                       tx_irq,
    output logic                       rx_irq,
    output logic                       dma_enabled
);
    localparam int NREQ = 2;   // index 0 transmit, 1 receive

    logic              rdf;
    logic              tde;
    logic              pend;
    logic              dma_bit;
    logic [1:0]        flags;
    logic [NREQ-1:0]   conds;
    logic [NREQ-1:0]   dreq;
    logic [NREQ-1:0]   ireq;
    hdm_pkg::dsp_stat_t stat;

    // Host to DSP direction; no flush on this side.
    hdm_channel #(.W(DATA_W)) u_h2d (
        .clk(clk), .rst_n(rst_n),
        .src_wr(host_tx_wr), .src_data(host_tx_data), .src_flush(1'b0),
        .dst_rd(dsp_rx_rd),
        .src_empty(host_tx_empty), .dst_full(rdf), .dst_data(dsp_rx_data)
    );

    // DSP to host direction; host initialize flushes the source.
    hdm_channel #(.W(DATA_W)) u_d2h (
        .clk(clk), .rst_n(rst_n),
        .src_wr(dsp_tx_wr), .src_data(dsp_tx_data), .src_flush(host_init),
        .dst_rd(host_rx_rd),
        .src_empty(tde), .dst_full(host_rx_full), .dst_data(host_rx_data)
    );

    hdm_host_ctl #(.VEC_W(VEC_W)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(host_ctl_wr), .ctl_flags(host_ctl_flags), .ctl_dma(host_ctl_dma),
        .cmd_set(host_cmd_set), .cmd_clr(host_cmd_clr), .cmd_vec_in(host_cmd_vec),
        .cmd_ack(cmd_ack),
        .flags(flags), .dma_bit(dma_bit), .cmd_pend(pend), .cmd_vec(cmd_vector)
    );

    // Pin mode suppresses host DMA.
    assign dma_enabled = dma_bit && !host_pin_mode;
    assign conds       = {rdf, tde};

    hdm_req #(.N(NREQ)) u_req (
        .cond(conds), .dma_on(dma_enabled), .dma_req(dreq), .irq(ireq)
    );

    assign tx_dma_req = dreq[0];
    assign rx_dma_req = dreq[1];
    assign tx_irq     = ireq[0];
    assign rx_irq     = ireq[1];

    // Status word assembly.
    assign stat.hflag = flags;
    assign stat.hcp   = pend;
    assign stat.tde   = tde;
    assign stat.rdf   = rdf;
    assign dsp_status = stat;

    assign cmd_irq       = pend;
    assign host_cmd_busy = pend;

    // R10: pin mode never shows an enabled DMA.
    p_pin_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_pin_mode |-> !dma_enabled);
    // R9: a condition never goes to both destinations.
    p_route_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_dma_req && tx_irq) && !(rx_dma_req && rx_irq));
    // R6: initialize leaves the transmit-empty status bit set.
    p_init_tde_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_init |=> dsp_status[1]);
endmodule

// File: tb/sim_hostdsp_mailbox.sv
// Bench: behavioural reference model compared on every clock.
module sim_hostdsp_mailbox;
    localparam int DW = 24;
    localparam int VW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = !clk;   // 125 MHz

    logic          host_tx_wr = 0, host_rx_rd = 0, host_ctl_wr = 0;
    logic [DW-1:0] host_tx_data = '0, dsp_tx_data = '0;
    logic [1:0]    host_ctl_flags = '0;
    logic          host_ctl_dma = 0, host_pin_mode = 0, host_init = 0;
    logic          host_cmd_set = 0, host_cmd_clr = 0, cmd_ack = 0;
    logic [VW-1:0] host_cmd_vec = '0;
    logic          dsp_tx_wr = 0, dsp_rx_rd = 0;

    logic          host_tx_empty, host_rx_full, host_cmd_busy, cmd_irq;
    logic [DW-1:0] host_rx_data, dsp_rx_data;
    logic [4:0]    dsp_status;
    logic [VW-1:0] cmd_vector;
    logic          tx_dma_req, rx_dma_req, tx_irq, rx_irq, dma_enabled;

    hostdsp_mailbox #(.DATA_W(DW), .VEC_W(VW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data), .host_tx_empty(host_tx_empty),
        .host_rx_rd(host_rx_rd), .host_rx_data(host_rx_data), .host_rx_full(host_rx_full),
        .host_ctl_wr(host_ctl_wr), .host_ctl_flags(host_ctl_flags), .host_ctl_dma(host_ctl_dma),
        .host_pin_mode(host_pin_mode), .host_init(host_init),
        .host_cmd_set(host_cmd_set), .host_cmd_clr(host_cmd_clr), .host_cmd_vec(host_cmd_vec),
        .host_cmd_busy(host_cmd_busy),
        .dsp_tx_wr(dsp_tx_wr), .dsp_tx_data(dsp_tx_data), .dsp_rx_rd(dsp_rx_rd),
        .dsp_rx_data(dsp_rx_data), .dsp_status(dsp_status),
        .cmd_irq(cmd_irq), .cmd_vector(cmd_vector), .cmd_ack(cmd_ack),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
        .tx_irq(tx_irq), .rx_irq(rx_irq), .dma_enabled(dma_enabled)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state.
    logic [DW-1:0] m_htx, m_drx, m_dtx, m_hrx;
    logic          m_htx_e, m_rdf, m_tde, m_hrxf, m_dma, m_cmd;
    logic [1:0]    m_hf;
    logic [VW-1:0] m_vec;

    // Model update from the inputs seen at this edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_htx = '0; m_drx = '0; m_dtx = '0; m_hrx = '0;
            m_htx_e = 1; m_rdf = 0; m_tde = 1; m_hrxf = 0;
            m_dma = 0; m_cmd = 0; m_hf = '0; m_vec = '0;
        end else begin
            bit mv_h, mv_d;
            mv_h = !m_htx_e && !m_rdf;
            mv_d = !m_tde && !m_hrxf && !host_init;
            if (mv_h) begin m_drx = m_htx; m_rdf = 1; end
            else if (dsp_rx_rd) m_rdf = 0;
            if (host_tx_wr) begin m_htx = host_tx_data; m_htx_e = 0; end
            else if (mv_h) m_htx_e = 1;
            if (mv_d) begin m_hrx = m_dtx; m_hrxf = 1; end
            else if (host_rx_rd) m_hrxf = 0;
            if (host_init) m_tde = 1;
            else if (dsp_tx_wr) begin m_dtx = dsp_tx_data; m_tde = 0; end
            else if (mv_d) m_tde = 1;
            if (host_ctl_wr) begin m_hf = host_ctl_flags; m_dma = host_ctl_dma; end
            if (host_cmd_clr) m_cmd = 0;
            else if (host_cmd_set) begin m_cmd = 1; m_vec = host_cmd_vec; end
            else if (cmd_ack) m_cmd = 0;
        end
    end

    // Compare every output against the model.
    task automatic compare_all();
        logic en;
        en = m_dma && !host_pin_mode;
        check("R2 R4 status[0] receive-full", dsp_status[0], m_rdf);
        check("R2 R5 R6 status[1] transmit-empty", dsp_status[1], m_tde);
        check("R2 R8 status[2] command pending", dsp_status[2], m_cmd);
        check("R2 R7 status[4:3] host flags", dsp_status[4:3], m_hf);
        check("R3 host_tx_empty", host_tx_empty, m_htx_e);
        if (m_rdf) check("R3 dsp_rx_data", dsp_rx_data, m_drx);
        check("R5 host_rx_full", host_rx_full, m_hrxf);
        if (m_hrxf) check("R5 host_rx_data", host_rx_data, m_hrx);
        check("R8 cmd_irq", cmd_irq, m_cmd);
        check("R8 host_cmd_busy", host_cmd_busy, m_cmd);
        if (m_cmd) check("R8 cmd_vector", cmd_vector, m_vec);
        check("R10 dma_enabled", dma_enabled, en);
        check("R9 tx_dma_req", tx_dma_req, m_tde && en);
        check("R9 rx_dma_req", rx_dma_req, m_rdf && en);
        check("R9 tx_irq", tx_irq, m_tde && !en);
        check("R9 rx_irq", rx_irq, m_rdf && !en);
    endtask

    task automatic idle_inputs();
        host_tx_wr = 0; host_rx_rd = 0; host_ctl_wr = 0; host_init = 0;
        host_cmd_set = 0; host_cmd_clr = 0; cmd_ack = 0;
        dsp_tx_wr = 0; dsp_rx_rd = 0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset values.
        check("R1 dsp_status after reset", dsp_status, 5'b00010);
        check("R1 host_tx_empty after reset", host_tx_empty, 1'b1);
        check("R1 host_rx_full after reset", host_rx_full, 1'b0);
        check("R1 cmd_irq after reset", cmd_irq, 1'b0);
        check("R1 dma_enabled after reset", dma_enabled, 1'b0);

        // Directed: R3 then R4 read colliding with an arrival.
        host_tx_data = 24'hA5A5A5; host_tx_wr = 1;
        @(negedge clk); compare_all(); idle_inputs();
        @(negedge clk); compare_all();
        check("R3 first word arrived", dsp_rx_data, 24'hA5A5A5);
        host_tx_data = 24'h123456; host_tx_wr = 1;
        @(negedge clk); compare_all(); idle_inputs();
        dsp_rx_rd = 1;   // read while the held word is about to move in
        @(negedge clk); compare_all(); idle_inputs();
        @(negedge clk); compare_all();
        check("R4 arrival beats read", dsp_status[0], 1'b1);
        check("R4 new word shown", dsp_rx_data, 24'h123456);

        // Directed: R6 initialize beats DSP write.
        dsp_tx_data = 24'h0F0F0F; dsp_tx_wr = 1; host_init = 1;
        @(negedge clk); compare_all(); idle_inputs();
        check("R6 init beats DSP write", dsp_status[1], 1'b1);
        @(negedge clk); compare_all();
        check("R6 no word reaches host", host_rx_full, 1'b0);

        // Directed: R10 pin mode gating.
        host_ctl_dma = 1; host_ctl_wr = 1;
        @(negedge clk); compare_all(); idle_inputs();
        check("R10 DMA bit enables", dma_enabled, 1'b1);
        host_pin_mode = 1;
        #1 check("R10 pin mode suppresses DMA", dma_enabled, 1'b0);
        @(negedge clk); compare_all();

        // Mixed random traffic, compared every clock.
        for (int cyc = 0; cyc < 4000; cyc++) begin
            host_tx_wr     = ($urandom % 4) == 0;
            host_tx_data   = DW'($urandom);
            host_rx_rd     = ($urandom % 3) == 0;
            dsp_tx_wr      = ($urandom % 4) == 0;
            dsp_tx_data    = DW'($urandom);
            dsp_rx_rd      = ($urandom % 3) == 0;
            host_ctl_wr    = ($urandom % 8) == 0;
            host_ctl_flags = 2'($urandom);
            host_ctl_dma   = 1'($urandom);
            host_init      = ($urandom % 16) == 0;
            host_cmd_set   = ($urandom % 6) == 0;
            host_cmd_clr   = ($urandom % 12) == 0;
            host_cmd_vec   = VW'($urandom);
            cmd_ack        = ($urandom % 5) == 0;
            if (($urandom % 32) == 0) host_pin_mode = !host_pin_mode;
            @(negedge clk);
            compare_all();
        end
        idle_inputs();
        done = 1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end
endmodule